// File: doc/BRIEF.md
# Mobile SDRAM Low-Power Mode Sequencer

This block sits on the controller side of a mobile SDRAM and looks after the memory's power-saving settings. On request it builds the extended mode register word and issues the write. The word carries three fields: how much of the array is kept alive in self refresh, the case-temperature band that sets the self-refresh rate, and the strength of the output drivers. Before it takes a request, the block checks each field against its list of legal codes. A request that uses a reserved code is refused with an error pulse, and the memory is not touched.

The block also runs deep power-down. It waits until every bank is idle, then issues the entry command with clock-enable low. It holds clock-enable low until an exit request arrives. After exit it issues only NOP cycles for a parameterised recovery window. It then raises a flag telling the surrounding controller that a full initialisation must follow, because the array contents are gone.

A pending command of either kind waits for the all-banks-idle indication. While a sequence is running, new requests are not accepted.

Top module: `lpdram_pwr_seq`

## Requirements
- R1: After reset the pins show a NOP (chip select low; row strobe, column strobe and write enable high), clock-enable is high, bank and address are zero, and ready, error and reinit are all low.
- R2: An accepted configuration request produces exactly one command cycle, and only while banks are idle. In that cycle chip select, row strobe, column strobe and write enable are all low and the bank bits are 2'b10 (upper bit 1, lower bit 0).
- R3: The address bits in that cycle carry the word: bits [2:0] are the array-coverage code, bits [4:3] the temperature code, bits [6:5] the drive code, and every higher bit is zero. The array codes are 000 all banks, 001 two banks, 010 one bank, 101 half bank, 110 quarter bank. The temperature codes are 00, 01, 10 and 11, for 70, 45, 15 and 85 degrees. The drive codes are 00 full, 01 half and 10 quarter.
- R4: The ready output is high for exactly one cycle, and that cycle is two cycles after the extended mode register command cycle.
- R5: While the all-banks-idle input is low, a pending extended mode register write or power-down entry is held back and the pins show NOP.
- R6: A configuration request with array code 011, 100 or 111, or with drive code 11, raises the error output for one cycle in the next cycle. No command is issued and the block stays idle.
- R7: Power-down entry is one cycle with chip select and write enable low, row and column strobes high, and clock-enable low. It is issued once banks are idle.
- R8: From entry until the cycle in which the exit input is sampled, clock-enable stays low, and chip select is high in every cycle after the entry cycle.
- R9: After exit is sampled, the next RECOV_CYC cycles show NOP with clock-enable high and reinit low. Reinit then rises and stays high until the next request is accepted.
- R10: Requests that arrive while a sequence is in progress are ignored. An exit request outside power-down is ignored. When a configuration request and an entry request arrive together, the configuration request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Configuration request strobe |
| cfgArray | input | 3 | Requested self-refresh array coverage code |
| cfgTemp | input | 2 | Requested temperature band code |
| cfgDrive | input | 2 | Requested output drive code |
| banksIdle | input | 1 | All banks idle, no burst in progress |
| dpdEnter | input | 1 | Deep power-down entry request |
| dpdExit | input | 1 | Deep power-down exit request |
| memCke | output | 1 | Clock enable to memory |
| memCsN | output | 1 | Chip select, active low |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write enable, active low |
| memBa | output | 2 | Bank select bits |
| memAddr | output | ADDR_W | Address bits |
| cfgReady | output | 1 | One-cycle pulse after a completed register write |
| cfgError | output | 1 | One-cycle pulse for a refused request |
| reinitReq | output | 1 | Full initialisation required after power-down exit |

## Verification
The hardest case to reach is a request that lands inside a window the block must not leave early. Examples are a configuration or entry request during the post-exit recovery count, or while a pending command is stalled because banks are busy. The stimulus holds the all-banks-idle input low for several cycles and, meanwhile, sends conflicting requests with different field values. It also sends configuration and entry requests partway through the recovery window. The bench's cycle model then confirms that none of these leave a trace on the pins, on ready or on reinit.

// File: rtl/lpseq_pkg.sv
package lpseq_pkg;

  typedef struct packed {
    logic loadCfg;
    logic issueEmr;
    logic issueDpd;
    logic holdDpd;
    logic pulseReady;
    logic pulseErr;
    logic setReinit;
    logic clrReinit;
  } seqStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CFG_PEND,
    ST_GAP,
    ST_DPD_PEND,
    ST_DPD_HOLD,
    ST_RECOVER
  } seqState_t;

  localparam logic [1:0] BANK_EMR = 2'b10;

  localparam logic [2:0] ARRAY_DEFAULT = 3'b000;
  localparam logic [1:0] TEMP_DEFAULT  = 2'b11;
  localparam logic [1:0] DRIVE_DEFAULT = 2'b00;

  function automatic logic arrayReserved(input logic [2:0] code);
    return (code == 3'b011) || (code == 3'b100) || (code == 3'b111);
  endfunction

endpackage

// File: rtl/lpseq_ctrl.sv
module lpseq_ctrl
  import lpseq_pkg::*;
#(
  parameter int RECOV_CYC = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgValid,
  input  logic [2:0] cfgArray,
  input  logic [1:0] cfgDrive,
  input  logic       banksIdle,
  input  logic       dpdEnter,
  input  logic       dpdExit,
  output seqStrobe_t strobe
);

  localparam int GAP_CYC = 2;
  localparam int CNT_W   = ($clog2(RECOV_CYC + 1) > 2) ? $clog2(RECOV_CYC + 1) : 2;

  seqState_t        state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             cfgReserved;

  assign cfgReserved = arrayReserved(cfgArray) || (cfgDrive == 2'b11);

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (cfgValid) begin
          if (cfgReserved) begin
            strobe.pulseErr = 1'b1;
          end else begin
            strobe.loadCfg   = 1'b1;
            strobe.clrReinit = 1'b1;
            nextState        = ST_CFG_PEND;
          end
        end else if (dpdEnter) begin
          strobe.clrReinit = 1'b1;
          nextState        = ST_DPD_PEND;
        end
      end
      ST_CFG_PEND: begin
        if (banksIdle) begin
          strobe.issueEmr = 1'b1;
          nextCnt         = CNT_W'(GAP_CYC - 1);
          nextState       = ST_GAP;
        end
      end
      ST_GAP: begin
        if (cnt == '0) begin
          strobe.pulseReady = 1'b1;
          nextState         = ST_IDLE;
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      ST_DPD_PEND: begin
        if (banksIdle) begin
          strobe.issueDpd = 1'b1;
          nextState       = ST_DPD_HOLD;
        end
      end
      ST_DPD_HOLD: begin
        if (dpdExit) begin
          nextCnt   = CNT_W'(RECOV_CYC - 1);
          nextState = ST_RECOVER;
        end else begin
          strobe.holdDpd = 1'b1;
        end
      end
      ST_RECOVER: begin
        if (cnt == '0) begin
          strobe.setReinit = 1'b1;
          nextState        = ST_IDLE;
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
    end
  end

  // R5: a pending write waits while banks are busy
  assert_pend_stall_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CFG_PEND && !banksIdle) |=> (state == ST_CFG_PEND));

  // R8: power-down is held until exit is requested
  assert_dpd_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DPD_HOLD && !dpdExit) |=> (state == ST_DPD_HOLD));

  // R10: recovery is never cut short by a request
  assert_recover_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECOVER && cnt != '0) |=> (state == ST_RECOVER));

endmodule

// File: rtl/lpseq_dpath.sv
module lpseq_dpath
  import lpseq_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [2:0]        cfgArray,
  input  logic [1:0]        cfgTemp,
  input  logic [1:0]        cfgDrive,
  output logic              memCke,
  output logic              memCsN,
  output logic              memRasN,
  output logic              memCasN,
  output logic              memWeN,
  output logic [1:0]        memBa,
  output logic [ADDR_W-1:0] memAddr,
  output logic              cfgReady,
  output logic              cfgError,
  output logic              reinitReq
);

  logic [2:0]        arrayQ;
  logic [1:0]        tempQ;
  logic [1:0]        driveQ;
  logic [ADDR_W-1:0] emrWord;
  logic              emrCyc;

  always_comb begin
    emrWord      = '0;
    emrWord[2:0] = arrayQ;
    emrWord[4:3] = tempQ;
    emrWord[6:5] = driveQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      arrayQ <= ARRAY_DEFAULT;
      tempQ  <= TEMP_DEFAULT;
      driveQ <= DRIVE_DEFAULT;
    end else if (strobe.loadCfg) begin
      arrayQ <= cfgArray;
      tempQ  <= cfgTemp;
      driveQ <= cfgDrive;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memCke    <= 1'b1;
      memCsN    <= 1'b0;
      memRasN   <= 1'b1;
      memCasN   <= 1'b1;
      memWeN    <= 1'b1;
      memBa     <= '0;
      memAddr   <= '0;
      cfgReady  <= 1'b0;
      cfgError  <= 1'b0;
      reinitReq <= 1'b0;
    end else begin
      memCke   <= 1'b1;
      memCsN   <= 1'b0;
      memRasN  <= 1'b1;
      memCasN  <= 1'b1;
      memWeN   <= 1'b1;
      memBa    <= '0;
      memAddr  <= '0;
      if (strobe.issueEmr) begin
        memRasN <= 1'b0;
        memCasN <= 1'b0;
        memWeN  <= 1'b0;
        memBa   <= BANK_EMR;
        memAddr <= emrWord;
      end else if (strobe.issueDpd) begin
        memWeN <= 1'b0;
        memCke <= 1'b0;
      end else if (strobe.holdDpd) begin
        memCsN <= 1'b1;
        memCke <= 1'b0;
      end
      cfgReady <= strobe.pulseReady;
      cfgError <= strobe.pulseErr;
      if (strobe.setReinit)      reinitReq <= 1'b1;
      else if (strobe.clrReinit) reinitReq <= 1'b0;
    end
  end

  assign emrCyc = !memCsN && !memRasN && !memCasN && !memWeN;

  // R4: ready follows the register write by two cycles
  assert_ready_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    cfgReady |-> $past(emrCyc, 2));

  // R6: a refusal is never followed by a command
  assert_err_no_cmd_R6: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> !emrCyc);

  // R7: clock-enable only falls on the entry command
  assert_dpd_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCke) |-> (!memCsN && memRasN && memCasN && !memWeN));

  // R8: after the entry cycle the bus is inhibited while clock-enable is low
  assert_dpd_inhibit_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!memCke && !$fell(memCke)) |-> memCsN);

  // R9: reinit rises only on a NOP with clock-enable high
  assert_reinit_nop_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reinitReq) |-> (memCke && !memCsN && memRasN && memCasN && memWeN));

endmodule

// File: rtl/lpdram_pwr_seq.sv
module lpdram_pwr_seq
  import lpseq_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int RECOV_CYC = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgValid,
  input  logic [2:0]        cfgArray,
  input  logic [1:0]        cfgTemp,
  input  logic [1:0]        cfgDrive,
  input  logic              banksIdle,
  input  logic              dpdEnter,
  input  logic              dpdExit,
  output logic              memCke,
  output logic              memCsN,
  output logic              memRasN,
  output logic              memCasN,
  output logic              memWeN,
  output logic [1:0]        memBa,
  output logic [ADDR_W-1:0] memAddr,
  output logic              cfgReady,
  output logic              cfgError,
  output logic              reinitReq
);

  seqStrobe_t strobe;

  lpseq_ctrl #(.RECOV_CYC(RECOV_CYC)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfgValid (cfgValid),
    .cfgArray (cfgArray),
    .cfgDrive (cfgDrive),
    .banksIdle(banksIdle),
    .dpdEnter (dpdEnter),
    .dpdExit  (dpdExit),
    .strobe   (strobe)
  );

  lpseq_dpath #(.ADDR_W(ADDR_W)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfgArray (cfgArray),
    .cfgTemp  (cfgTemp),
    .cfgDrive (cfgDrive),
    .memCke   (memCke),
    .memCsN   (memCsN),
    .memRasN  (memRasN),
    .memCasN  (memCasN),
    .memWeN   (memWeN),
    .memBa    (memBa),
    .memAddr  (memAddr),
    .cfgReady (cfgReady),
    .cfgError (cfgError),
    .reinitReq(reinitReq)
  );

endmodule

// File: tb/lpdram_pwr_seq_tb_top.sv
module lpdram_pwr_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 13;
  localparam int RECOV      = 12;

  logic clk = 1'b0;
  logic rstN, cfgValid, banksIdle, dpdEnter, dpdExit;
  logic [2:0] cfgArray;
  logic [1:0] cfgTemp, cfgDrive;
  logic memCke, memCsN, memRasN, memCasN, memWeN, cfgReady, cfgError, reinitReq;
  logic [1:0] memBa;
  logic [ADDR_W-1:0] memAddr;

  int nChecks = 0;
  int nFail   = 0;
  bit running = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lpdram_pwr_seq #(.ADDR_W(ADDR_W), .RECOV_CYC(RECOV)) dut_i (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgArray(cfgArray),
    .cfgTemp(cfgTemp), .cfgDrive(cfgDrive), .banksIdle(banksIdle),
    .dpdEnter(dpdEnter), .dpdExit(dpdExit), .memCke(memCke), .memCsN(memCsN),
    .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN), .memBa(memBa),
    .memAddr(memAddr), .cfgReady(cfgReady), .cfgError(cfgError),
    .reinitReq(reinitReq)
  );

  // behavioural reference: mode 0 idle, 1 write waiting, 2 write done,
  // 3 entry waiting, 4 powered down, 5 recovering
  int mode = 0, waitCnt = 0;
  logic [3:0] eCmd;
  logic eCke, eRdy, eErr, eRein;
  logic [1:0] eBa;
  logic [ADDR_W-1:0] eAddr;
  logic [6:0] heldWord;

  function automatic bit isReserved(logic [2:0] a, logic [1:0] d);
    return (a == 3'd3) || (a == 3'd4) || (a == 3'd7) || (d == 2'd3);
  endfunction

  always @(posedge clk) begin
    eCmd = 4'b0111; eCke = 1'b1; eBa = 2'b00; eAddr = '0; eRdy = 1'b0; eErr = 1'b0;
    if (!rstN) begin
      mode = 0; waitCnt = 0; eRein = 1'b0;
    end else begin
      case (mode)
        0: if (cfgValid) begin
             if (isReserved(cfgArray, cfgDrive)) eErr = 1'b1;
             else begin heldWord = {cfgDrive, cfgTemp, cfgArray}; eRein = 1'b0; mode = 1; end
           end else if (dpdEnter) begin eRein = 1'b0; mode = 3; end
        1: if (banksIdle) begin
             eCmd = 4'b0000; eBa = 2'b10; eAddr = ADDR_W'(heldWord); waitCnt = 0; mode = 2;
           end
        2: if (waitCnt == 0) waitCnt = 1; else begin eRdy = 1'b1; mode = 0; end
        3: if (banksIdle) begin eCmd = 4'b0110; eCke = 1'b0; mode = 4; end
        4: if (dpdExit) begin waitCnt = RECOV; mode = 5; end
           else begin eCmd = 4'b1111; eCke = 1'b0; end
        5: begin waitCnt--; if (waitCnt == 0) begin eRein = 1'b1; mode = 0; end end
        default: mode = 0;
      endcase
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      chk("R2 R5 R7 R10 command pins", {memCsN, memRasN, memCasN, memWeN}, eCmd);
      chk("R3 bank/address", {memBa, memAddr}, {eBa, eAddr});
      chk("R8 R9 clock-enable", memCke, eCke);
      chk("R4 ready", cfgReady, eRdy);
      chk("R6 error", cfgError, eErr);
      chk("R9 reinit", reinitReq, eRein);
    end
  end

  task automatic sendCfg(logic [2:0] a, logic [1:0] t, logic [1:0] d, int gap);
    cfgValid = 1'b1; cfgArray = a; cfgTemp = t; cfgDrive = d;
    @(negedge clk);
    cfgValid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; cfgValid = 1'b0; banksIdle = 1'b1; dpdEnter = 1'b0; dpdExit = 1'b0;
    cfgArray = '0; cfgTemp = '0; cfgDrive = '0;
    repeat (3) @(negedge clk);
    running = 1'b1;
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset command", {memCke, memCsN, memRasN, memCasN, memWeN}, 5'b10111);
    chk("R1 reset address", {memBa, memAddr}, '0);
    chk("R1 reset flags", {cfgReady, cfgError, reinitReq}, 3'b000);

    sendCfg(3'd5, 2'd1, 2'd2, 5);                        // R2 R3 R4
    banksIdle = 1'b0;                                    // R5 stalled write
    sendCfg(3'd2, 2'd0, 2'd1, 6);
    banksIdle = 1'b1;
    repeat (5) @(negedge clk);
    sendCfg(3'd3, 2'd0, 2'd0, 3);                        // R6 reserved codes
    sendCfg(3'd4, 2'd2, 2'd1, 3);
    sendCfg(3'd7, 2'd3, 2'd0, 3);
    sendCfg(3'd0, 2'd1, 2'd3, 3);
    banksIdle = 1'b0;                                    // R10 busy requests
    cfgValid = 1'b1; cfgArray = 3'd1; cfgTemp = 2'd2; cfgDrive = 2'd0;
    @(negedge clk);
    cfgArray = 3'd6; cfgTemp = 2'd3; cfgDrive = 2'd1; dpdEnter = 1'b1;
    repeat (2) @(negedge clk);
    cfgValid = 1'b0; dpdEnter = 1'b0; banksIdle = 1'b1;
    repeat (6) @(negedge clk);
    dpdEnter = 1'b1;                                     // R10 priority
    sendCfg(3'd6, 2'd0, 2'd2, 0);
    dpdEnter = 1'b0;
    repeat (6) @(negedge clk);
    pulse(dpdExit);                                      // R10 exit when idle
    repeat (3) @(negedge clk);

    banksIdle = 1'b0;                                    // R5 R7 R8 R9
    pulse(dpdEnter);
    repeat (4) @(negedge clk);
    banksIdle = 1'b1;
    repeat (10) @(negedge clk);
    pulse(dpdExit);
    repeat (3) @(negedge clk);
    sendCfg(3'd1, 2'd1, 2'd1, 0);                        // R10 during recovery
    pulse(dpdEnter);
    repeat (RECOV + 5) @(negedge clk);
    sendCfg(3'd0, 2'd3, 2'd0, 6);                        // R9 reinit clears

    pulse(dpdEnter);                                     // short power-down
    repeat (2) @(negedge clk);
    pulse(dpdExit);
    repeat (RECOV + 4) @(negedge clk);

    for (int a = 0; a < 8; a++)                          // R3 R6 full sweep
      for (int t = 0; t < 4; t++)
        for (int d = 0; d < 4; d++)
          sendCfg(3'(a), 2'(t), 2'(d), 3);

    repeat (4) @(negedge clk);
    running = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule